// File: doc/BRIEF.md
# USB Host Transaction Retry Controller

This block sits beside a USB host packet engine. It decides whether a finished host transaction is sent again or closed, and it runs the retry timer that limits how long a token may keep being retried. Each transaction reports its end status once: the handshake kind plus four error flags. The block answers in one of two ways. It can ask the engine to send the same token again. Or it can close the transaction, which emits a one-cycle completion pulse and updates the final status outputs in the same cycle.

The retry timer is loaded when software issues a new token. It counts down once per bit-time tick while a transaction is in flight or waiting to be reissued. When a retry is decided inside the end-of-frame window, the block parks. In that state no reissue is requested and the timer holds its value. Once the next start-of-frame token has ended with the SOF interrupt flag still clear, the block leaves the park and counting continues from the held value.

The end status arrives on a valid/ready channel. Ready is high only while a transaction is in flight. A status offered while ready is low is not taken and has no effect. The engine keeps valid and the status fields steady until the cycle in which both valid and ready are high. Every other pin is plain level or strobe control.

Top module: `hretry_ctrl`

## Requirements
- R1: After reset the block is idle. `end_ready`, `reissue_req` and `done_pulse` are 0, `fin_hs` is 3 (no handshake) and `fin_err` is 0.
- R2: Handshake codes are 0 ACK, 1 NAK, 2 STALL and 3 none. Error bits are bit0 size overrun, bit1 timeout, bit2 CRC and bit3 bit-stuffing. An end status is retryable when its code is NAK, or when its code is "none" and at least one error bit is set. A retryable status accepted with retry enabled, the timer non-zero, the SOF flag clear, no disconnect and outside the EOF window raises `reissue_req` in the next cycle.
- R3: An accepted ACK or STALL always closes the transaction, whatever the error bits are: `done_pulse` is high in the next cycle and no reissue is requested.
- R4: An accepted retryable status also closes the transaction in the next cycle if any of these is true: retry is disabled, `disconn` is high, `sof_irq` is high, or the timer is already 0.
- R5: `tok_issue` while idle loads `tmr_reload` into the timer. The timer drops by one on each `bit_tick` while the transaction is in flight or waiting for reissue. It stops at 0.
- R6: While a reissue is pending, a timer at 0 closes the transaction. With a tick every cycle from a value V, `done_pulse` appears after V+1 cycles.
- R7: `reissue_req` stays high until `eng_start`. After `eng_start` the request drops and `end_ready` rises in the next cycle.
- R8: While a reissue is pending, a low `retry_en`, a high `disconn` or a high `sof_irq` closes the transaction in the next cycle.
- R9: A retry decided while `eof_area` is high parks the block. It raises no request, and the timer ignores `bit_tick`.
- R10: In park, `sof_done` with `sof_irq` low raises `reissue_req` in the next cycle, and counting continues from the held value. In park, a high `sof_irq`, a high `disconn` or a low `retry_en` closes the transaction instead.
- R11: `done_pulse` lasts one cycle. `fin_hs` and `fin_err` change only in that cycle, and they then carry the last accepted end status.
- R12: An `end_valid` offered while `end_ready` is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| retry_en | input | 1 | Retry enable |
| tmr_reload | input | TMR_W | Retry timer load value |
| bit_tick | input | 1 | One pulse per bit time |
| eof_area | input | 1 | High inside the end-of-frame window |
| sof_done | input | 1 | Strobe: an SOF token has ended |
| sof_irq | input | 1 | SOF interrupt flag |
| disconn | input | 1 | Device disconnection detected |
| tok_issue | input | 1 | New token issued by software (accepted when idle) |
| eng_start | input | 1 | Engine has started the reissued token |
| end_valid | input | 1 | End status valid |
| end_ready | output | 1 | End status accepted this cycle when valid |
| end_hs | input | 2 | Handshake code of the finished transaction |
| end_err | input | 4 | Error flags of the finished transaction |
| reissue_req | output | 1 | Request to send the token again |
| done_pulse | output | 1 | One-cycle completion pulse |
| fin_hs | output | 2 | Final handshake code |
| fin_err | output | 4 | Final error flags |

## Verification
The hardest situation to reach is a timer frozen in the park state that then resumes exactly where it stopped. To get there, the stimulus first spends a known number of ticks while the transaction is in flight. It then hands in a NAK with `eof_area` high and applies a long run of ticks while parked. Finally it pulses `sof_done` and counts the cycles until `done_pulse`. That count must equal the reload value, minus the ticks spent in flight, plus one. The sweeps cover every reload value from 1 to 6 and every number of in-flight ticks up to and including the reload value, so the point where the timer reaches 0 exactly at decision time is exercised too.

// File: rtl/hretry_pkg.sv
package hretry_pkg;
  localparam int ERR_W   = 4;
  localparam int E_SIZE  = 0;
  localparam int E_TOUT  = 1;
  localparam int E_CRC   = 2;
  localparam int E_STUFF = 3;

  typedef enum logic [1:0] {
    HS_ACK   = 2'd0,
    HS_NAK   = 2'd1,
    HS_STALL = 2'd2,
    HS_NONE  = 2'd3
  } hs_e;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_FLIGHT = 2'd1,
    PH_WAIT   = 2'd2,
    PH_PARK   = 2'd3
  } phase_e;

  typedef struct packed {
    logic [1:0]       hs;
    logic [ERR_W-1:0] err;
  } end_stat_t;
endpackage

// File: rtl/hretry_judge.sv
module hretry_judge
  import hretry_pkg::*;
(
  input  end_stat_t st,
  output logic      terminal,
  output logic      retryable
);
  logic [ERR_W-1:0] err_seen;
  logic             any_err;

  // one slot per error class, so the set of retry causes can grow without rewriting the reduction
  for (genvar g = 0; g < ERR_W; g++) begin : g_err
    assign err_seen[g] = st.err[g];
  end

  always_comb begin
    any_err   = |err_seen;
    terminal  = (st.hs == HS_ACK) || (st.hs == HS_STALL);
    retryable = !terminal && ((st.hs == HS_NAK) || any_err);
  end
endmodule

// File: rtl/hretry_timer.sv
module hretry_timer #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         run,
  input  logic         tick,
  output logic [W-1:0] value,
  output logic         zero
);
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value <= '0;
    end else if (load) begin
      value <= load_val;
    end else if (run && tick && (value != '0)) begin
      value <= value - ONE;
    end
  end

  assign zero = (value == '0);
endmodule

// File: rtl/hretry_fsm.sv
module hretry_fsm
  import hretry_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   tok_issue,
  input  logic   eng_start,
  input  logic   end_valid,
  input  logic   terminal,
  input  logic   retryable,
  input  logic   retry_en,
  input  logic   disconn,
  input  logic   sof_irq,
  input  logic   sof_done,
  input  logic   eof_area,
  input  logic   tmr_zero,
  output phase_e phase,
  output logic   accept,
  output logic   finish,
  output logic   tmr_load,
  output logic   tmr_run
);
  phase_e nxt;
  logic   halt_ext;

  assign halt_ext = !retry_en || disconn || sof_irq;
  assign accept   = (phase == PH_FLIGHT) && end_valid;
  assign tmr_load = (phase == PH_IDLE) && tok_issue;
  assign tmr_run  = (phase == PH_FLIGHT) || (phase == PH_WAIT);

  always_comb begin
    nxt    = phase;
    finish = 1'b0;
    unique case (phase)
      PH_IDLE: begin
        if (tok_issue) nxt = PH_FLIGHT;
      end
      PH_FLIGHT: begin
        if (end_valid) begin
          if (terminal || !retryable || halt_ext || tmr_zero) begin
            finish = 1'b1;
            nxt    = PH_IDLE;
          end else if (eof_area) begin
            nxt = PH_PARK;
          end else begin
            nxt = PH_WAIT;
          end
        end
      end
      PH_WAIT: begin
        if (halt_ext || tmr_zero) begin
          finish = 1'b1;
          nxt    = PH_IDLE;
        end else if (eng_start) begin
          nxt = PH_FLIGHT;
        end
      end
      PH_PARK: begin
        if (halt_ext) begin
          finish = 1'b1;
          nxt    = PH_IDLE;
        end else if (sof_done) begin
          nxt = PH_WAIT;
        end
      end
      default: nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= nxt;
  end
endmodule

// File: rtl/hretry_ctrl.sv
module hretry_ctrl
  import hretry_pkg::*;
#(
  parameter int TMR_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             retry_en,
  input  logic [TMR_W-1:0] tmr_reload,
  input  logic             bit_tick,
  input  logic             eof_area,
  input  logic             sof_done,
  input  logic             sof_irq,
  input  logic             disconn,
  input  logic             tok_issue,
  input  logic             eng_start,
  input  logic             end_valid,
  output logic             end_ready,
  input  logic [1:0]       end_hs,
  input  logic [ERR_W-1:0] end_err,
  output logic             reissue_req,
  output logic             done_pulse,
  output logic [1:0]       fin_hs,
  output logic [ERR_W-1:0] fin_err
);
  localparam end_stat_t STAT_RST = '{hs: HS_NONE, err: '0};

  end_stat_t        in_stat, last_q, fin_q;
  logic             terminal, retryable;
  logic             accept, finish, tmr_load, tmr_run, tmr_zero;
  logic [TMR_W-1:0] tmr_val;
  logic             done_q;
  phase_e           phase;

  assign in_stat = '{hs: end_hs, err: end_err};

  hretry_judge u_judge (
    .st        (in_stat),
    .terminal  (terminal),
    .retryable (retryable)
  );

  hretry_timer #(.W(TMR_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_reload),
    .run      (tmr_run),
    .tick     (bit_tick),
    .value    (tmr_val),
    .zero     (tmr_zero)
  );

  hretry_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .tok_issue (tok_issue),
    .eng_start (eng_start),
    .end_valid (end_valid),
    .terminal  (terminal),
    .retryable (retryable),
    .retry_en  (retry_en),
    .disconn   (disconn),
    .sof_irq   (sof_irq),
    .sof_done  (sof_done),
    .eof_area  (eof_area),
    .tmr_zero  (tmr_zero),
    .phase     (phase),
    .accept    (accept),
    .finish    (finish),
    .tmr_load  (tmr_load),
    .tmr_run   (tmr_run)
  );

  // last accepted status; the final outputs copy it (or the incoming one) only on closing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= STAT_RST;
      fin_q  <= STAT_RST;
      done_q <= 1'b0;
    end else begin
      done_q <= finish;
      if (accept) last_q <= in_stat;
      if (finish) fin_q  <= accept ? in_stat : last_q;
    end
  end

  assign end_ready   = (phase == PH_FLIGHT);
  assign reissue_req = (phase == PH_WAIT);
  assign done_pulse  = done_q;
  assign fin_hs      = fin_q.hs;
  assign fin_err     = fin_q.err;

  logic unused_ok;
  assign unused_ok = ^tmr_val;
endmodule

// File: rtl/hretry_chk.sv
module hretry_chk
  import hretry_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             retry_en,
  input logic             eof_area,
  input logic             sof_irq,
  input logic             disconn,
  input logic             eng_start,
  input logic             end_valid,
  input logic             end_ready,
  input logic [1:0]       end_hs,
  input logic             reissue_req,
  input logic             done_pulse,
  input logic [1:0]       fin_hs,
  input logic [ERR_W-1:0] fin_err
);
  a_r12_ready_vs_req: assert property (@(posedge clk) disable iff (!rst_n)
    end_ready |-> !reissue_req);

  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse);

  a_r11_fin_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !done_pulse |-> ($stable(fin_hs) && $stable(fin_err)));

  a_r3_ack_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (end_valid && end_ready && end_hs == HS_ACK) |=> (done_pulse && fin_hs == HS_ACK));

  a_r3_stall_no_retry: assert property (@(posedge clk) disable iff (!rst_n)
    (end_valid && end_ready && end_hs == HS_STALL) |=> (!reissue_req && done_pulse));

  a_r4_disabled_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (end_valid && end_ready && !retry_en) |=> (!reissue_req && done_pulse));

  a_r8_disconn_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (reissue_req && disconn) |=> done_pulse);

  a_r9_eof_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    (end_valid && end_ready && eof_area) |=> !reissue_req);

  a_r7_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (reissue_req && !eng_start && retry_en && !disconn && !sof_irq) |=> (reissue_req || done_pulse));
endmodule

bind hretry_ctrl hretry_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .retry_en    (retry_en),
  .eof_area    (eof_area),
  .sof_irq     (sof_irq),
  .disconn     (disconn),
  .eng_start   (eng_start),
  .end_valid   (end_valid),
  .end_ready   (end_ready),
  .end_hs      (end_hs),
  .reissue_req (reissue_req),
  .done_pulse  (done_pulse),
  .fin_hs      (fin_hs),
  .fin_err     (fin_err)
);

// File: tb/tb_hretry_ctrl.sv
`timescale 1ns/1ps
module tb_hretry_ctrl;
  localparam int TW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          retry_en = 1'b1;
  logic [TW-1:0] tmr_reload = '0;
  logic          bit_tick = 1'b0, eof_area = 1'b0, sof_done = 1'b0, sof_irq = 1'b0;
  logic          disconn = 1'b0, tok_issue = 1'b0, eng_start = 1'b0, end_valid = 1'b0;
  logic [1:0]    end_hs = 2'd3;
  logic [3:0]    end_err = 4'd0;
  logic          end_ready, reissue_req, done_pulse;
  logic [1:0]    fin_hs;
  logic [3:0]    fin_err;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  hretry_ctrl #(.TMR_W(TW)) dut (.*);

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic start_tok(int rl);
    tmr_reload = TW'(rl);
    tok_issue = 1'b1;
    step();
    tok_issue = 1'b0;
  endtask

  task automatic ticks(int n);
    bit_tick = 1'b1;
    repeat (n) step();
    bit_tick = 1'b0;
  endtask

  task automatic give_end(int hs, int err);
    end_valid = 1'b1;
    end_hs = 2'(hs);
    end_err = 4'(err);
    step();
    end_valid = 1'b0;
  endtask

  // ticks every cycle until the completion pulse; returns the cycle count
  task automatic count_done(output int k);
    k = 0;
    bit_tick = 1'b1;
    for (int i = 1; i <= 60; i++) begin
      step();
      if (done_pulse) begin
        k = i;
        break;
      end
    end
    bit_tick = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int k;
    repeat (3) step();
    // R1 reset state
    check("R1 end_ready", int'(end_ready), 0);
    check("R1 reissue_req", int'(reissue_req), 0);
    check("R1 done_pulse", int'(done_pulse), 0);
    check("R1 fin_hs", int'(fin_hs), 3);
    check("R1 fin_err", int'(fin_err), 0);
    rst_n = 1'b1;
    step();

    // R5 R6 R2 R4: reload and in-flight tick sweep, NAK end
    for (int rl = 1; rl <= 6; rl++) begin
      for (int t = 0; t <= rl; t++) begin
        start_tok(rl);
        check("R5 ready after issue", int'(end_ready), 1);
        ticks(t);
        give_end(1, 0);
        if (t < rl) begin
          check("R2 nak retried", int'(reissue_req), 1);
          count_done(k);
          check("R6 cycles to done", k, rl - t + 1);
          check("R11 fin_hs nak", int'(fin_hs), 1);
        end else begin
          check("R4 zero timer closes", int'(done_pulse), 1);
          check("R4 zero timer no req", int'(reissue_req), 0);
        end
        step();
      end
    end

    // R2 R7 R12: each retry cause, request held, ignored status, acknowledge
    for (int c = 0; c < 5; c++) begin
      int err = (c == 0) ? 0 : (1 << (c - 1));
      int hs  = (c == 0) ? 1 : 3;
      start_tok(30);
      give_end(hs, err);
      check("R2 cause retried", int'(reissue_req), 1);
      end_valid = 1'b1; end_hs = 2'd0;
      step();
      end_valid = 1'b0;
      check("R12 ignored while waiting", int'(done_pulse), 0);
      check("R12 req intact", int'(reissue_req), 1);
      step(); step();
      check("R7 req held", int'(reissue_req), 1);
      eng_start = 1'b1;
      step();
      eng_start = 1'b0;
      check("R7 req dropped", int'(reissue_req), 0);
      check("R7 ready again", int'(end_ready), 1);
      give_end(0, 0);
      check("R3 ack closes", int'(done_pulse), 1);
      check("R11 fin after ack", int'(fin_hs) * 16 + int'(fin_err), 0);
      step();
    end

    // R3 R11: ACK or STALL with all errors set
    for (int h = 0; h <= 2; h += 2) begin
      start_tok(30);
      give_end(h, 15);
      check("R3 terminal done", int'(done_pulse), 1);
      check("R3 terminal no req", int'(reissue_req), 0);
      check("R11 fin_hs", int'(fin_hs), h);
      check("R11 fin_err", int'(fin_err), 15);
      step();
      check("R11 done one cycle", int'(done_pulse), 0);
    end

    // R4: stop conditions present at decision time
    for (int s = 0; s < 3; s++) begin
      start_tok(30);
      retry_en = (s != 0); disconn = (s == 1); sof_irq = (s == 2);
      give_end(1, 0);
      check("R4 stop at end", int'(done_pulse), 1);
      check("R4 no req", int'(reissue_req), 0);
      retry_en = 1'b1; disconn = 1'b0; sof_irq = 1'b0;
      step();
    end

    // R8 R11: stop conditions while reissue pending, stored status reported
    for (int s = 0; s < 3; s++) begin
      start_tok(30);
      give_end(3, 2);
      check("R8 waiting", int'(reissue_req), 1);
      retry_en = (s != 0); disconn = (s == 1); sof_irq = (s == 2);
      step();
      check("R8 closed", int'(done_pulse), 1);
      check("R11 stored status", int'(fin_hs) * 16 + int'(fin_err), 3 * 16 + 2);
      retry_en = 1'b1; disconn = 1'b0; sof_irq = 1'b0;
      step();
    end

    // R9 R10: park in EOF, frozen timer, resume from held value
    start_tok(5);
    ticks(1);
    eof_area = 1'b1;
    give_end(1, 0);
    eof_area = 1'b0;
    check("R9 no req in park", int'(reissue_req), 0);
    check("R9 not closed", int'(done_pulse), 0);
    ticks(10);
    check("R9 frozen no done", int'(done_pulse), 0);
    check("R9 still parked", int'(reissue_req), 0);
    sof_done = 1'b1;
    step();
    sof_done = 1'b0;
    check("R10 resume req", int'(reissue_req), 1);
    count_done(k);
    check("R10 resumed count", k, 5);
    step();

    // R10: SOF flag set while parked closes
    start_tok(5);
    eof_area = 1'b1;
    give_end(3, 8);
    eof_area = 1'b0;
    sof_irq = 1'b1;
    step();
    sof_irq = 1'b0;
    check("R10 park closed by sof flag", int'(done_pulse), 1);
    check("R11 park status", int'(fin_err), 8);
    step();

    // R12: status offered while idle is ignored
    end_valid = 1'b1; end_hs = 2'd0; end_err = 4'd5;
    step(); step();
    end_valid = 1'b0;
    check("R12 idle no done", int'(done_pulse), 0);
    check("R12 idle fin kept", int'(fin_err), 8);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule